// File: doc/BRIEF.md
# Demand-Mode DMA Bus Handshake Controller

This block sits between an external requester and a four-channel DMA engine. The external device first asks for the data bus. The controller hands the bus over with a bus-available signal. The device then raises a transfer request, and the controller turns that request into a one-cycle service pulse for one of the engine's channels.

A request that lands in the descriptor window (the second sampled cycle after the grant) makes the controller capture the data bus as a transfer descriptor. The target channel is read from the two low bits of that descriptor. Outside the window, a request alone goes to a default channel. A request seen together with a bus-release request goes straight to channel 2.

Each accepted request is answered by an acknowledge strobe to the device, carrying the served channel number. All external pins are active-low and are registered once before any decision is made.

Top module: `dmd_bus_hs`

## Requirements
- R1: While reset is held, and at the first clock after it, bus_avail_n and ack_n are 1, chan_id is 0, svc_req is 0 and desc_q is 0.
- R2: With no grant outstanding, a low breq_n (with treq_n high) that follows a sampled high on breq_n is captured at clock edge e, and bus_avail_n then goes low after edge e+1.
- R3: Let g be the edge at which bus_avail_n went low. If treq_n is low at edge g+2, the data bus sampled at that edge is stored in desc_q. svc_req bit data[1:0] then pulses after edge g+3.
- R4: A low treq_n sampled at edge g+1 (the first edge after the grant) is ignored: no svc_req pulse follows, and bus_avail_n stays low.
- R5: treq_n low with breq_n high, sampled while idle or after the descriptor window, pulses svc_req bit DFLT_CH (0 by default) two edges after the sample.
- R6: treq_n and breq_n sampled low together outside the descriptor window pulse svc_req bit 2 and do not start a grant. Inside the window, the descriptor decision takes precedence.
- R7: ack_n is low for the single cycle that follows an svc_req pulse, with chan_id equal to the index of the pulsed bit. chan_id is 0 whenever ack_n is high.
- R8: bus_avail_n returns high in the same cycle as the svc_req pulse that consumes the grant. Holding breq_n low afterwards does not produce a new grant; breq_n must go high and then low again.
- R9: svc_req (bit i requests channel i) has at most one bit set, and each accepted request sets it for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| breq_n | input | 1 | Bus-release request from the external device, active low |
| treq_n | input | 1 | Transfer request from the external device, active low |
| data_bus | input | DW | Data bus, sampled as a descriptor in the window |
| bus_avail_n | output | 1 | Bus granted to the external device, active low |
| ack_n | output | 1 | Acknowledge strobe to the external device, active low |
| chan_id | output | 2 | Channel served by the current acknowledge |
| svc_req | output | 4 | One-cycle service pulse per DMA channel |
| desc_q | output | DW | Last captured transfer descriptor |

## Verification
The descriptor decision and the direct channel 2 path can both be triggered in one sampled cycle. This happens when the device still holds breq_n low from its bus request and drops treq_n exactly at the window edge. The bench provokes this with a descriptor whose low bits name channel 3. It then checks that bit 3 pulses, that bit 2 stays low, and that the descriptor register holds the driven value. A separate scenario drops both pins together while idle, to check that the direct channel 2 path still works on its own.

// File: rtl/dmd_pkg.sv
// Package for the demand-mode bus handshake controller.
// Holds the channel count, the channel width and the types shared between
// the grant sequencer and the acknowledge generator.
package dmd_pkg;
    localparam int NCH       = 4;
    localparam int CHW       = $clog2(NCH);
    localparam int DIRECT_CH = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1
    } hs_state_t;

    typedef struct packed {
        logic           valid;
        logic [CHW-1:0] ch;
    } accept_t;
endpackage

// File: rtl/dmd_in_reg.sv
// Input stage: turns the active-low pins into active-high levels and
// registers them once. A second, delayed copy of the bus-release request
// lets the sequencer find a new request edge.
// Assumes the pins are already synchronous to clk.
module dmd_in_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          breq_n,
    input  logic          treq_n,
    input  logic [DW-1:0] data_bus,
    output logic          breq_s,
    output logic          breq_d,
    output logic          treq_s,
    output logic [DW-1:0] data_s
);
    // Register the pins and keep the previous bus-request level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            breq_s <= 1'b0;
            breq_d <= 1'b0;
            treq_s <= 1'b0;
            data_s <= '0;
        end else begin
            breq_s <= ~breq_n;
            breq_d <= breq_s;
            treq_s <= ~treq_n;
            data_s <= data_bus;
        end
    end
endmodule

// File: rtl/dmd_grant_fsm.sv
// Grant sequencer: grants the bus on a new bus-release request, counts the
// cycles since the grant and decides what each registered transfer request
// means: a descriptor (in the window), a direct channel request, or a
// default-channel request.
// Assumes its inputs come from dmd_in_reg, one register after the pins.
module dmd_grant_fsm
    import dmd_pkg::*;
#(
    parameter int DW      = 8,
    parameter int WIN     = 2,
    parameter int DFLT_CH = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          breq_s,
    input  logic          breq_d,
    input  logic          treq_s,
    input  logic [DW-1:0] data_s,
    output logic          bav,
    output accept_t       acc,
    output logic [DW-1:0] desc
);
    localparam int CNTW = $clog2(WIN + 2);
    localparam logic [CNTW-1:0] CNT_WIN = CNTW'(WIN);
    localparam logic [CNTW-1:0] CNT_SAT = CNTW'(WIN + 1);
    localparam logic [CHW-1:0]  CH_DIR  = CHW'(DIRECT_CH);
    localparam logic [CHW-1:0]  CH_DEF  = CHW'(DFLT_CH);

    hs_state_t       st, st_nx;
    logic [CNTW-1:0] cnt, cnt_nx;
    logic            bav_nx;
    accept_t         acc_nx;
    logic [DW-1:0]   desc_nx;

    // Next-state decision for grant, window counting and request decode.
    always_comb begin
        st_nx   = st;
        cnt_nx  = cnt;
        bav_nx  = bav;
        acc_nx  = '0;
        desc_nx = desc;
        case (st)
            ST_IDLE: begin
                if (treq_s) begin
                    acc_nx.valid = 1'b1;
                    acc_nx.ch    = breq_s ? CH_DIR : CH_DEF;
                end else if (breq_s && !breq_d) begin
                    st_nx  = ST_GRANT;
                    bav_nx = 1'b1;
                    cnt_nx = '0;
                end
            end
            ST_GRANT: begin
                if (cnt != CNT_SAT) cnt_nx = cnt + 1'b1;
                if (treq_s && cnt == CNT_WIN) begin
                    desc_nx      = data_s;
                    acc_nx.valid = 1'b1;
                    acc_nx.ch    = data_s[CHW-1:0];
                    st_nx        = ST_IDLE;
                    bav_nx       = 1'b0;
                end else if (treq_s && cnt == CNT_SAT) begin
                    acc_nx.valid = 1'b1;
                    acc_nx.ch    = breq_s ? CH_DIR : CH_DEF;
                    st_nx        = ST_IDLE;
                    bav_nx       = 1'b0;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State, counter, grant, accept and descriptor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            bav  <= 1'b0;
            acc  <= '0;
            desc <= '0;
        end else begin
            st   <= st_nx;
            cnt  <= cnt_nx;
            bav  <= bav_nx;
            acc  <= acc_nx;
            desc <= desc_nx;
        end
    end
endmodule

// File: rtl/dmd_ack_gen.sv
// Acknowledge generator: decodes an accepted request into one-hot channel
// pulses and, one cycle later, drives the acknowledge strobe with the
// channel number. The channel number is zero while the strobe is idle.
// Assumes acc is valid for one cycle per accepted request.
module dmd_ack_gen
    import dmd_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  accept_t        acc,
    output logic [NCH-1:0] svc,
    output logic           ack,
    output logic [CHW-1:0] ack_ch
);
    // One decoder per channel.
    for (genvar i = 0; i < NCH; i++) begin : g_dec
        assign svc[i] = acc.valid && (acc.ch == CHW'(i));
    end

    // Strobe and channel number, one cycle behind the accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack    <= 1'b0;
            ack_ch <= '0;
        end else begin
            ack    <= acc.valid;
            ack_ch <= acc.valid ? acc.ch : '0;
        end
    end
endmodule

// File: rtl/dmd_bus_hs.sv
// Top of the demand-mode bus handshake controller. Connects the input
// stage, the grant sequencer and the acknowledge generator. It also converts
// the active-high internal grant and strobe back to active-low pins.
// Assumes all pins are synchronous to clk and reset is synchronous.
module dmd_bus_hs
    import dmd_pkg::*;
#(
    parameter int DW      = 8,
    parameter int WIN     = 2,
    parameter int DFLT_CH = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           breq_n,
    input  logic           treq_n,
    input  logic [DW-1:0]  data_bus,
    output logic           bus_avail_n,
    output logic           ack_n,
    output logic [CHW-1:0] chan_id,
    output logic [NCH-1:0] svc_req,
    output logic [DW-1:0]  desc_q
);
    logic          breq_s, breq_d, treq_s, bav, ack;
    logic [DW-1:0] data_s;
    accept_t       acc;

    dmd_in_reg #(.DW(DW)) u_in (
        .clk(clk), .rst_n(rst_n), .breq_n(breq_n), .treq_n(treq_n),
        .data_bus(data_bus), .breq_s(breq_s), .breq_d(breq_d),
        .treq_s(treq_s), .data_s(data_s)
    );

    dmd_grant_fsm #(.DW(DW), .WIN(WIN), .DFLT_CH(DFLT_CH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .breq_s(breq_s), .breq_d(breq_d),
        .treq_s(treq_s), .data_s(data_s), .bav(bav), .acc(acc),
        .desc(desc_q)
    );

    dmd_ack_gen u_ack (
        .clk(clk), .rst_n(rst_n), .acc(acc), .svc(svc_req),
        .ack(ack), .ack_ch(chan_id)
    );

    assign bus_avail_n = ~bav;
    assign ack_n       = ~ack;
endmodule

// File: rtl/dmd_bus_hs_chk.sv
// Checker for dmd_bus_hs: relates the pins over time. Bound to the top below.
module dmd_bus_hs_chk
    import dmd_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           breq_n,
    input logic           bus_avail_n,
    input logic           ack_n,
    input logic [CHW-1:0] chan_id,
    input logic [NCH-1:0] svc_req
);
    a_r9_svc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(svc_req));

    a_r7_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (|svc_req) |=> !ack_n);

    a_r7_id_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n |-> (chan_id == '0));

    a_r7_id_direct: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req[DIRECT_CH] |=> (chan_id == CHW'(DIRECT_CH)));

    a_r8_release_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (|svc_req) |-> bus_avail_n);

    a_r2_grant_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_avail_n) |-> ($past(breq_n, 2) == 1'b0));
endmodule

bind dmd_bus_hs dmd_bus_hs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .breq_n(breq_n), .bus_avail_n(bus_avail_n),
    .ack_n(ack_n), .chan_id(chan_id), .svc_req(svc_req)
);

// File: tb/tb_dmd_bus_hs.sv
module tb_dmd_bus_hs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       breq_n = 1'b1;
    logic       treq_n = 1'b1;
    logic [7:0] data_bus = '0;
    logic       bus_avail_n, ack_n;
    logic [1:0] chan_id;
    logic [3:0] svc_req;
    logic [7:0] desc_q;
    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dmd_bus_hs dut (
        .clk(clk), .rst_n(rst_n), .breq_n(breq_n), .treq_n(treq_n),
        .data_bus(data_bus), .bus_avail_n(bus_avail_n), .ack_n(ack_n),
        .chan_id(chan_id), .svc_req(svc_req), .desc_q(desc_q)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Raise the bus request; returns just after the grant edge g.
    task automatic grant();
        breq_n = 1'b0;
        tick();
        tick();
        chk("R2 grant latency", bus_avail_n, 0);
    endtask

    task automatic t_reset();
        tick(); tick();
        chk("R1 bav", bus_avail_n, 1);
        chk("R1 ack", ack_n, 1);
        chk("R1 id", chan_id, 0);
        chk("R1 svc", svc_req, 0);
        chk("R1 desc", desc_q, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 bav after release", bus_avail_n, 1);
        chk("R1 svc after release", svc_req, 0);
    endtask

    task automatic t_descriptor(input logic [7:0] d);
        grant();
        tick();                           // now past g+1
        treq_n = 1'b0; data_bus = d;      // sampled at g+2
        tick();
        treq_n = 1'b1; data_bus = '0;
        chk("R3 bav held in window", bus_avail_n, 0);
        tick();                           // g+3
        chk("R3 svc from descriptor", svc_req, 4'b1 << d[1:0]);
        chk("R3 descriptor latched", desc_q, d);
        chk("R8 bav released", bus_avail_n, 1);
        tick();
        chk("R7 ack low", ack_n, 0);
        chk("R7 ack id", chan_id, d[1:0]);
        chk("R9 svc single cycle", svc_req, 0);
        tick();
        chk("R7 ack single cycle", ack_n, 1);
        chk("R7 id zero when idle", chan_id, 0);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R8 no regrant while held", bus_avail_n, 1);
        end
        breq_n = 1'b1;
        tick(); tick();
    endtask

    task automatic t_early_then_default();
        grant();
        treq_n = 1'b0;                    // sampled at g+1
        tick();
        treq_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R4 early svc ignored", svc_req, 0);
            chk("R4 bav still granted", bus_avail_n, 0);
        end
        breq_n = 1'b1; treq_n = 1'b0;
        tick();
        treq_n = 1'b1;
        tick();
        chk("R5 default channel after window", svc_req, 4'b0001);
        chk("R8 bav released", bus_avail_n, 1);
        tick();
        chk("R7 ack after default", ack_n, 0);
        chk("R7 id default", chan_id, 0);
        tick(); tick();
    endtask

    task automatic t_idle_default();
        treq_n = 1'b0;
        tick();
        treq_n = 1'b1;
        tick();
        chk("R5 idle default svc", svc_req, 4'b0001);
        tick();
        chk("R7 idle ack", ack_n, 0);
        chk("R9 svc cleared", svc_req, 0);
        tick(); tick();
    endtask

    task automatic t_direct();
        breq_n = 1'b0; treq_n = 1'b0;
        tick();
        breq_n = 1'b1; treq_n = 1'b1;
        tick();
        chk("R6 direct ch2 svc", svc_req, 4'b0100);
        chk("R6 no grant", bus_avail_n, 1);
        tick();
        chk("R7 direct ack", ack_n, 0);
        chk("R7 direct id", chan_id, 2);
        chk("R6 still no grant", bus_avail_n, 1);
        tick(); tick();
    endtask

    task automatic t_collide();
        grant();
        tick();
        treq_n = 1'b0; data_bus = 8'hA3;  // breq_n still low at g+2
        tick();
        treq_n = 1'b1; data_bus = '0;
        tick();
        chk("R6 window wins over direct", svc_req, 4'b1000);
        chk("R3 collide descriptor", desc_q, 8'hA3);
        tick();
        chk("R7 collide id", chan_id, 3);
        breq_n = 1'b1;
        tick(); tick();
    endtask

    initial begin
        t_reset();
        t_descriptor(8'h5E);
        t_descriptor(8'h31);
        t_early_then_default();
        t_idle_default();
        t_direct();
        t_collide();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule